// File: doc/BRIEF.md
# Two-Stage Deadline Watchdog

This block supervises software liveness against a shared, free-running 64-bit platform time value. It keeps no counter of its own. Software holds off the watchdog by repeatedly writing a first deadline that lies in the future. When platform time moves strictly beyond that deadline, the block raises an interrupt toward a processor hart. It also arms a second stage that watches a second deadline.

If the armed second stage sees time move strictly beyond its own deadline, the block raises a reset request toward an external management controller. A fresh write to the first deadline before that point withdraws the hart interrupt and disarms the second stage. Once the reset request has been raised, only disabling the block or resetting it clears it.

Configuration uses a simple synchronous register port with a combinational read path. The second deadline can be written at any time, but it is evaluated only while the second stage is armed.

Top module: `dual_deadline_watchdog`

## Requirements
- R1: After reset, irq_hart and rst_request are low, and the enable bit and both deadline registers read back as zero.
- R2: The register map is as follows. Address 0 bit 0 is the enable bit. Address 1 holds the first deadline and address 2 holds the second deadline, both full-width. A write to address 3 is ignored and address 3 reads as zero. rd_data follows rd_addr combinationally.
- R3: While enabled, if time_now is strictly greater than the first deadline in a cycle, irq_hart is high from the next cycle. If time_now equals the deadline, nothing happens.
- R4: Once raised, irq_hart stays high until a write to the first deadline, a disable, or a reset.
- R5: The second stage is armed only by an expiry of the first stage. A second deadline already in the past causes no reset request while irq_hart is low.
- R6: While the second stage is armed and time_now is strictly greater than the second deadline, rst_request is high from the next cycle. It is never raised earlier than one cycle after irq_hart.
- R7: A write to the first deadline drops irq_hart in the next cycle and disarms the second stage. The write takes priority over a first-stage expiry in the same cycle.
- R8: rst_request is sticky: later writes to the first deadline do not clear it.
- R9: If a first-deadline write and a second-stage expiry fall in the same cycle, rst_request is still raised and irq_hart is dropped.
- R10: Writing 0 to the enable bit drops both outputs from the next cycle and disarms the second stage. After re-enabling, an expired first deadline trips again.
- R11: When the first stage expires again after a refresh, the second stage re-arms and compares against the current second deadline.
- R12: Both comparisons are unsigned over the full 64 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 64 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 64 | Register read data (combinational) |
| time_now | input | 64 | Shared platform time value |
| irq_hart | output | 1 | First-stage interrupt toward a hart |
| rst_request | output | 1 | Second-stage reset request toward the management controller |

## Verification
Two functions can land on the same clock edge, and each collision is provoked on purpose.

The first collision is a refresh write to the first deadline in the very cycle that the armed second stage sees time pass its deadline. The bench drives the new time value and the write strobe together and expects rst_request high and irq_hart low one cycle later.

The second collision is a refresh write in the cycle where time has already passed the old first deadline. Here the write must win, so irq_hart is expected to stay low.

A behavioural model in the bench recomputes both outputs every cycle and flags any divergence around these edges.

// File: rtl/ddw_pkg.sv
package ddw_pkg;
  localparam int TIME_W_DEF = 64;
  localparam int ADDR_W     = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL = 2'd0,
    REG_DL1  = 2'd1,
    REG_DL2  = 2'd2,
    REG_RSVD = 2'd3
  } ddw_reg_e;

  localparam int NUM_STAGES = 2;
endpackage

// File: rtl/ddw_regs.sv
module ddw_regs
  import ddw_pkg::*;
#(
  parameter int TIME_W = TIME_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [TIME_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [TIME_W-1:0] rd_data,
  output logic              en_q,
  output logic [TIME_W-1:0] dl1_q,
  output logic [TIME_W-1:0] dl2_q,
  output logic              dl1_wr,
  output logic              ctrl_wr
);
  logic dl2_wr;

  always_comb begin
    ctrl_wr = wr_en && (wr_addr == REG_CTRL);
    dl1_wr  = wr_en && (wr_addr == REG_DL1);
    dl2_wr  = wr_en && (wr_addr == REG_DL2);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      dl1_q <= '0;
      dl2_q <= '0;
    end else begin
      if (ctrl_wr) en_q  <= wr_data[0];
      if (dl1_wr)  dl1_q <= wr_data;
      if (dl2_wr)  dl2_q <= wr_data;
    end
  end

  always_comb begin
    unique case (rd_addr)
      REG_CTRL: rd_data = {{(TIME_W-1){1'b0}}, en_q};
      REG_DL1:  rd_data = dl1_q;
      REG_DL2:  rd_data = dl2_q;
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/ddw_cmp.sv
module ddw_cmp #(
  parameter int TIME_W = 64
) (
  input  logic              gate,
  input  logic [TIME_W-1:0] now,
  input  logic [TIME_W-1:0] limit,
  output logic              hit
);
  function automatic logic beyond(input logic [TIME_W-1:0] t,
                                  input logic [TIME_W-1:0] lim);
    return t > lim;
  endfunction

  assign hit = gate && beyond(now, limit);
endmodule

// File: rtl/ddw_stages.sv
module ddw_stages (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic s1_hit,
  input  logic s2_hit,
  input  logic dl1_wr,
  output logic armed,
  output logic irq,
  output logic rst_req
);
  logic s1_q;
  logic rq_q;
  logic s1_d;
  logic rq_d;

  always_comb begin
    s1_d = en && !dl1_wr && (s1_q || s1_hit);
    rq_d = en && (rq_q || s2_hit);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      rq_q <= 1'b0;
    end else begin
      s1_q <= s1_d;
      rq_q <= rq_d;
    end
  end

  assign armed   = s1_q;
  assign irq     = s1_q && en;
  assign rst_req = rq_q && en;
endmodule

// File: rtl/dual_deadline_watchdog.sv
module dual_deadline_watchdog
  import ddw_pkg::*;
#(
  parameter int TIME_W = TIME_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [TIME_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [TIME_W-1:0] rd_data,
  input  logic [TIME_W-1:0] time_now,
  output logic              irq_hart,
  output logic              rst_request
);
  logic                                en_q;
  logic [TIME_W-1:0]                   dl1_q;
  logic [TIME_W-1:0]                   dl2_q;
  logic                                dl1_wr;
  logic                                ctrl_wr;
  logic                                armed;
  logic [NUM_STAGES-1:0]               gate;
  logic [NUM_STAGES-1:0]               hit;
  logic [NUM_STAGES-1:0][TIME_W-1:0]   limit;

  ddw_regs #(.TIME_W(TIME_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .en_q(en_q), .dl1_q(dl1_q), .dl2_q(dl2_q),
    .dl1_wr(dl1_wr), .ctrl_wr(ctrl_wr)
  );

  assign gate[0]  = en_q;
  assign gate[1]  = en_q && armed;
  assign limit[0] = dl1_q;
  assign limit[1] = dl2_q;

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_cmp
    ddw_cmp #(.TIME_W(TIME_W)) u_cmp (
      .gate(gate[g]), .now(time_now), .limit(limit[g]), .hit(hit[g])
    );
  end

  ddw_stages u_stages (
    .clk(clk), .rst_n(rst_n), .en(en_q), .s1_hit(hit[0]), .s2_hit(hit[1]),
    .dl1_wr(dl1_wr), .armed(armed), .irq(irq_hart), .rst_req(rst_request)
  );
endmodule

// File: rtl/ddw_checker.sv
module ddw_checker (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic s1_hit,
  input logic s2_hit,
  input logic dl1_wr,
  input logic ctrl_wr,
  input logic irq_hart,
  input logic rst_request
);
  p_s1_trip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_hit && !dl1_wr && !ctrl_wr) |=> irq_hart);

  p_refresh_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dl1_wr |=> !irq_hart);

  p_rst_after_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_request) |-> $past(irq_hart));

  p_s2_trip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_hit && !ctrl_wr) |=> rst_request);

  p_rst_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_request && !ctrl_wr) |=> rst_request);

  p_disabled_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!irq_hart && !rst_request));
endmodule

bind dual_deadline_watchdog ddw_checker u_chk (
  .clk(clk), .rst_n(rst_n), .en(en_q), .s1_hit(hit[0]), .s2_hit(hit[1]),
  .dl1_wr(dl1_wr), .ctrl_wr(ctrl_wr), .irq_hart(irq_hart),
  .rst_request(rst_request)
);

// File: tb/dual_deadline_watchdog_test.sv
module dual_deadline_watchdog_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [63:0] wr_data = 64'd0;
  logic [1:0]  rd_addr = 2'd0;
  logic [63:0] rd_data;
  logic [63:0] tnow = 64'd0;
  logic        irq_hart;
  logic        rst_request;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // behavioural reference state
  bit          m_en = 0;
  logic [63:0] m_d1 = 0;
  logic [63:0] m_d2 = 0;
  bit          m_trip = 0;
  bit          m_reset_out = 0;

  always #5 clk = ~clk;

  dual_deadline_watchdog uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .time_now(tnow), .irq_hart(irq_hart), .rst_request(rst_request)
  );

  // reference: deadlines are exceeded only when time is strictly later (unsigned)
  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_d1 = 0; m_d2 = 0; m_trip = 0; m_reset_out = 0;
    end else begin
      bit late1, late2, refresh;
      late1   = m_en && (tnow > m_d1);
      late2   = m_en && m_trip && (tnow > m_d2);
      refresh = wr_en && (wr_addr == 2'd1);
      if (!m_en) begin
        m_trip = 0; m_reset_out = 0;
      end else begin
        if (late2) m_reset_out = 1;
        if (refresh) m_trip = 0;
        else if (late1) m_trip = 1;
      end
      if (wr_en) begin
        if (wr_addr == 2'd0) m_en = wr_data[0];
        else if (wr_addr == 2'd1) m_d1 = wr_data;
        else if (wr_addr == 2'd2) m_d2 = wr_data;
      end
    end
  end

  // per-cycle comparison against the model (R3 R4 R6 R8)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks += 2;
      if (irq_hart !== (m_trip && m_en)) begin
        fails++;
        $display("FAIL model R3 irq_hart got %b exp %b at t=%0d", irq_hart, m_trip && m_en, tnow);
      end
      if (rst_request !== (m_reset_out && m_en)) begin
        fails++;
        $display("FAIL model R6 rst_request got %b exp %b at t=%0d", rst_request, m_reset_out && m_en, tnow);
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s got %0h exp %0h", tag, act, exp);
    end
  endtask

  // called just after a negedge; returns just after the next negedge
  task automatic wr(input logic [1:0] a, input logic [63:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input string tag, input logic [1:0] a, input logic [63:0] exp);
    rd_addr = a;
    #1;
    chk(tag, rd_data, exp);
  endtask

  initial begin
    tnow = 64'd100;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    chk("R1 irq_hart", irq_hart, 0);
    chk("R1 rst_request", rst_request, 0);
    rd("R1 ctrl", 2'd0, 0);
    rd("R1 dl1", 2'd1, 0);
    rd("R1 dl2", 2'd2, 0);

    wr(2'd1, 64'd200);
    wr(2'd2, 64'd50);
    wr(2'd3, 64'hFFFF);
    rd("R2 reserved reads zero", 2'd3, 0);
    rd("R2 dl1 readback", 2'd1, 64'd200);
    rd("R2 dl2 readback", 2'd2, 64'd50);
    wr(2'd0, 64'd1);
    rd("R2 ctrl readback", 2'd0, 64'd1);

    tnow = 64'd150;
    cyc(3);
    chk("R5 stale second deadline ignored", rst_request, 0);
    wr(2'd2, 64'd1000);

    tnow = 64'd200;
    cyc(2);
    chk("R3 equal time no trip", irq_hart, 0);
    tnow = 64'd201;
    cyc(1);
    chk("R3 trip one cycle later", irq_hart, 1);
    cyc(3);
    chk("R4 irq_hart held", irq_hart, 1);
    chk("R6 not yet past second", rst_request, 0);

    wr(2'd1, 64'd500);
    chk("R7 refresh drops irq", irq_hart, 0);
    tnow = 64'd1200;
    wr(2'd1, 64'd3000);
    chk("R7 refresh beats expiry", irq_hart, 0);
    cyc(2);
    chk("R7 stage two disarmed", rst_request, 0);

    wr(2'd2, 64'd2500);
    tnow = 64'd3001;
    cyc(1);
    chk("R11 rearm irq", irq_hart, 1);
    chk("R6 not in same cycle as irq", rst_request, 0);
    cyc(1);
    chk("R11 current second deadline used", rst_request, 1);

    wr(2'd1, 64'd9000);
    chk("R8 refresh leaves reset request", rst_request, 1);
    chk("R8 irq dropped", irq_hart, 0);
    cyc(3);
    chk("R8 still sticky", rst_request, 1);

    wr(2'd0, 64'd0);
    chk("R10 disable drops reset", rst_request, 0);
    chk("R10 disable drops irq", irq_hart, 0);
    wr(2'd1, 64'd10);
    tnow = 64'd20;
    cyc(2);
    chk("R10 disabled no trip", irq_hart, 0);
    wr(2'd0, 64'd1);
    cyc(1);
    chk("R10 reenable trips", irq_hart, 1);

    // collision: refresh write together with second-stage expiry (R9)
    wr(2'd2, 64'd100);
    tnow = 64'd101;
    wr(2'd1, 64'd9000);
    chk("R9 reset raised on collision", rst_request, 1);
    chk("R9 irq dropped on collision", irq_hart, 0);

    // unsigned comparisons (R12)
    wr(2'd0, 64'd0);
    wr(2'd1, 64'h8000_0000_0000_0000);
    wr(2'd2, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(2'd0, 64'd1);
    tnow = 64'h7FFF_FFFF_FFFF_FFFF;
    cyc(2);
    chk("R12 below top-bit deadline", irq_hart, 0);
    tnow = 64'h8000_0000_0000_0001;
    cyc(1);
    chk("R12 above top-bit deadline", irq_hart, 1);
    cyc(2);
    chk("R12 max second deadline never passed", rst_request, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired R1 got hang exp completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule